// File: doc/BRIEF.md
# Single-Cycle RV32I Subset Core

A 32-bit integer core that executes a reduced RV32I instruction set and retires one instruction on every rising clock edge. It fetches through a combinational instruction port (program counter out, instruction word in) and reaches data through a second port. That port carries an address, write data, a 4-bit byte-lane strobe, a load flag and returned read data. Memories and any memory-mapped devices live outside the block, and there are no stall cycles.

The supported operations are add, sub, and, or, sll, srl, sra, addi, andi, ori, lw, sw, beq, bne, jal, lui and auipc. The jump variant here redirects the program counter only and leaves its destination register untouched, so subroutine linking must be done in software if at all. Stores always cover a full word.

Top module: `rv_core`

## Requirements
- R1: A synchronous active-high `rst` forces the program counter to 0x00000000 at the clock edge where it is sampled high.
- R2: For every instruction other than a taken branch or a jump, the program counter advances by 4 at each clock edge.
- R3: Register-register add, sub, and, or (opcode 0110011; funct3 000 with funct7 bit 5 selecting sub, 110 or, 111 and) write the result of rs1 op rs2 to rd.
- R4: addi, andi and ori (opcode 0010011; funct3 000, 111, 110) combine rs1 with the sign-extended 12-bit immediate in bits 31:20.
- R5: lui (opcode 0110111) writes the 20-bit upper immediate shifted left by 12; auipc (opcode 0010111) writes that value plus the current program counter.
- R6: sll, srl, sra (opcode 0110011; funct3 001, 101, 101 with funct7 bit 5 high for sra) shift by the low 5 bits of rs2 only; sra replicates the sign bit.
- R7: sw (opcode 0100011, funct3 010) drives address rs1 plus the sign-extended S-type offset, write data rs2 and strobe 4'b1111 in the same cycle; the strobe is 4'b0000 for every other instruction.
- R8: lw (opcode 0000011, funct3 010) raises `dmem_rd_o`, drives address rs1 plus the I-type offset, and writes `dmem_rdata_i` into rd at the clock edge.
- R9: beq and bne (opcode 1100011; funct3 000, 001) compare rs1 and rs2 and, when taken, set the next program counter to PC plus the sign-extended B-type offset; otherwise PC plus 4.
- R10: jal (opcode 1101111) sets the next program counter to PC plus the sign-extended J-type offset and writes no register.
- R11: Register x0 reads as zero; writes addressed to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Fetch address (current program counter) |
| instr_i | input | 32 | Instruction word at `pc_o` |
| dmem_addr_o | output | 32 | Data address (ALU result) |
| dmem_wdata_o | output | 32 | Store data (rs2) |
| dmem_wstrb_o | output | 4 | Byte-lane write strobe, all lanes or none |
| dmem_rd_o | output | 1 | High when the read data is written back to rd |
| dmem_rdata_i | input | 32 | Data returned from memory |

## Verification
The program is built so that each result feeds a later store, which makes a wrong operation visible on the data port. A negative store offset and a negative immediate for ori catch a core that zero-extends immediates. A shift amount of 36 catches a core that uses more than five bits of rs2, and a negative operand separates sra from srl. A jal naming x5, followed by a store of x5, exposes a core that links. A write to x0 followed by a store of x0 exposes a writable x0. The read data bus carries a distinctive pattern in every cycle, so selecting memory data on non-load write-back corrupts later stores. Taken and untaken beq/bne, plus a backward branch, check the program-counter sequence. A mid-run reset checks the return to address zero.

// File: rtl/rv_core.sv
module rv_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  input  logic [31:0] instr_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic [3:0]  dmem_wstrb_o,
  output logic        dmem_rd_o,
  input  logic [31:0] dmem_rdata_i
);

  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  logic [31:0] pc_q;
  logic [31:0] regs [0:31];

  wire [6:0] opc  = instr_i[6:0];
  wire [4:0] rd   = instr_i[11:7];
  wire [2:0] f3   = instr_i[14:12];
  wire [4:0] rs1  = instr_i[19:15];
  wire [4:0] rs2  = instr_i[24:20];
  wire       alt  = instr_i[30];

  wire is_op    = opc == OPC_OP;
  wire is_opimm = opc == OPC_OPIMM;
  wire is_load  = opc == OPC_LOAD;
  wire is_store = opc == OPC_STORE;
  wire is_br    = opc == OPC_BR;
  wire is_jal   = opc == OPC_JAL;
  wire is_lui   = opc == OPC_LUI;
  wire is_auipc = opc == OPC_AUIPC;

  wire [31:0] imm_i = {{20{instr_i[31]}}, instr_i[31:20]};
  wire [31:0] imm_s = {{20{instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
  wire [31:0] imm_b = {{19{instr_i[31]}}, instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  wire [31:0] imm_u = {instr_i[31:12], 12'b0};
  wire [31:0] imm_j = {{11{instr_i[31]}}, instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};

  wire [31:0] rv1 = (rs1 == 5'd0) ? 32'd0 : regs[rs1];
  wire [31:0] rv2 = (rs2 == 5'd0) ? 32'd0 : regs[rs2];

  logic [31:0] opa, opb, alu;

  always_comb begin
    opa = rv1;
    opb = imm_i;
    if (is_op)         opb = rv2;
    else if (is_store) opb = imm_s;
    else if (is_lui)   begin opa = 32'd0; opb = imm_u; end
    else if (is_auipc) begin opa = pc_q;  opb = imm_u; end
  end

  always_comb begin
    alu = opa + opb;
    if (is_op || is_opimm) begin
      case (f3)
        3'b000:  alu = (is_op && alt) ? opa - opb : opa + opb;
        3'b001:  alu = opa << opb[4:0];
        3'b101:  alu = alt ? 32'($signed(opa) >>> opb[4:0]) : opa >> opb[4:0];
        3'b110:  alu = opa | opb;
        3'b111:  alu = opa & opb;
        default: alu = opa + opb;
      endcase
    end
  end

  wire        wr_en   = is_op | is_opimm | is_load | is_lui | is_auipc;
  wire [31:0] wb_data = is_load ? dmem_rdata_i : alu;

  always_ff @(posedge clk) begin
    if (wr_en && rd != 5'd0) regs[rd] <= wb_data;
  end

  wire        taken   = is_br & ((rv1 == rv2) ^ f3[0]);
  wire [31:0] pc_next = is_jal ? pc_q + imm_j :
                        taken  ? pc_q + imm_b :
                                 pc_q + 32'd4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign pc_o         = pc_q;
  assign dmem_addr_o  = alu;
  assign dmem_wdata_o = rv2;
  assign dmem_wstrb_o = {4{is_store}};
  assign dmem_rd_o    = is_load;

endmodule

// File: rtl/rv_core_chk.sv
module rv_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [3:0]  wstrb,
  input logic        rd_en
);

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen_q === 1'b1) AST_RESET_PC: assert (pc == 32'h0); // R1
  end

  wire [6:0] opc = instr[6:0];
  wire redirect = (opc == 7'b1100011) || (opc == 7'b1101111);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc == $past(pc) + 32'd4); // R2

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R2

  AST_STRB_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
    wstrb == 4'h0 || wstrb == 4'hF); // R7

  AST_STORE_STRB: assert property (@(posedge clk) disable iff (rst)
    (opc == 7'b0100011) |-> wstrb == 4'hF); // R7

  AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (opc == 7'b0000011) |-> (rd_en && wstrb == 4'h0)); // R8

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wstrb != 4'h0)); // R8

endmodule

bind rv_core rv_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_o), .instr(instr_i),
  .wstrb(dmem_wstrb_o), .rd_en(dmem_rd_o)
);

// File: tb/rv_core_bench.sv
module rv_core_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc_o, instr_i, dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic [3:0]  dmem_wstrb_o;
  logic        dmem_rd_o;

  always #2.5 clk = ~clk;

  rv_core u_rv_core (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_i(instr_i),
    .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o),
    .dmem_wstrb_o(dmem_wstrb_o), .dmem_rd_o(dmem_rd_o),
    .dmem_rdata_i(dmem_rdata_i)
  );

  function automatic logic [31:0] er(input logic [6:0] f7, input logic [4:0] s2, input logic [4:0] s1,
                                     input logic [2:0] f3, input logic [4:0] d);
    return {f7, s2, s1, f3, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] ei(input logic [11:0] im, input logic [4:0] s1, input logic [2:0] f3,
                                     input logic [4:0] d, input logic [6:0] op);
    return {im, s1, f3, d, op};
  endfunction
  function automatic logic [31:0] es(input logic [11:0] im, input logic [4:0] s2, input logic [4:0] s1);
    return {im[11:5], s2, s1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] eb(input logic [12:0] im, input logic [4:0] s2, input logic [4:0] s1,
                                     input logic [2:0] f3);
    return {im[12], im[10:5], s2, s1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] eu(input logic [19:0] im, input logic [4:0] d, input logic [6:0] op);
    return {im, d, op};
  endfunction
  function automatic logic [31:0] ej(input logic [20:0] im, input logic [4:0] d);
    return {im[20], im[10:1], im[11], im[19:12], d, 7'b1101111};
  endfunction

  localparam logic [6:0] OI = 7'b0010011;
  localparam logic [1:0] K_NONE = 2'd0, K_ST = 2'd1, K_LD = 2'd2;
  localparam logic [31:0] RDPAT = 32'hCAFE_F00D;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ins;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{32'd0,   ei(12'h005, 5'd0, 3'd0, 5'd1, OI),  K_NONE, 32'h0, 32'h0},
    '{32'd4,   ei(12'hFFD, 5'd0, 3'd0, 5'd2, OI),  K_NONE, 32'h0, 32'h0},
    '{32'd8,   er(7'h00, 5'd2, 5'd1, 3'd0, 5'd3),  K_NONE, 32'h0, 32'h0},
    '{32'd12,  es(12'h040, 5'd3, 5'd0),            K_ST, 32'h40, 32'h2},
    '{32'd16,  er(7'h20, 5'd2, 5'd1, 3'd0, 5'd4),  K_NONE, 32'h0, 32'h0},
    '{32'd20,  es(12'hFFC, 5'd4, 5'd1),            K_ST, 32'h1, 32'h8},
    '{32'd24,  er(7'h00, 5'd2, 5'd1, 3'd7, 5'd5),  K_NONE, 32'h0, 32'h0},
    '{32'd28,  ei(12'h0F0, 5'd2, 3'd7, 5'd6, OI),  K_NONE, 32'h0, 32'h0},
    '{32'd32,  er(7'h00, 5'd6, 5'd5, 3'd6, 5'd7),  K_NONE, 32'h0, 32'h0},
    '{32'd36,  ei(12'hF00, 5'd5, 3'd6, 5'd8, OI),  K_NONE, 32'h0, 32'h0},
    '{32'd40,  es(12'h000, 5'd7, 5'd6),            K_ST, 32'hF0, 32'hF5},
    '{32'd44,  es(12'h000, 5'd8, 5'd5),            K_ST, 32'h5, 32'hFFFF_FF05},
    '{32'd48,  eu(20'h12345, 5'd9, 7'b0110111),    K_NONE, 32'h0, 32'h0},
    '{32'd52,  eu(20'h00001, 5'd10, 7'b0010111),   K_NONE, 32'h0, 32'h0},
    '{32'd56,  es(12'h000, 5'd9, 5'd10),           K_ST, 32'h1034, 32'h1234_5000},
    '{32'd60,  ei(12'hF80, 5'd0, 3'd0, 5'd11, OI), K_NONE, 32'h0, 32'h0},
    '{32'd64,  ei(12'h024, 5'd0, 3'd0, 5'd13, OI), K_NONE, 32'h0, 32'h0},
    '{32'd68,  er(7'h20, 5'd13, 5'd11, 3'd5, 5'd12), K_NONE, 32'h0, 32'h0},
    '{32'd72,  er(7'h00, 5'd13, 5'd11, 3'd5, 5'd14), K_NONE, 32'h0, 32'h0},
    '{32'd76,  er(7'h00, 5'd13, 5'd11, 3'd1, 5'd15), K_NONE, 32'h0, 32'h0},
    '{32'd80,  es(12'h000, 5'd12, 5'd14),          K_ST, 32'h0FFF_FFF8, 32'hFFFF_FFF8},
    '{32'd84,  es(12'h000, 5'd15, 5'd0),           K_ST, 32'h0, 32'hFFFF_F800},
    '{32'd88,  ei(12'h007, 5'd0, 3'd0, 5'd0, OI),  K_NONE, 32'h0, 32'h0},
    '{32'd92,  es(12'h000, 5'd0, 5'd0),            K_ST, 32'h0, 32'h0},
    '{32'd96,  ei(12'h008, 5'd1, 3'd2, 5'd16, 7'b0000011), K_LD, 32'hD, 32'h0},
    '{32'd100, es(12'h000, 5'd16, 5'd0),           K_ST, 32'h0, RDPAT},
    '{32'd104, eb(13'h00C, 5'd1, 5'd1, 3'd0),      K_NONE, 32'h0, 32'h0},
    '{32'd116, eb(13'h064, 5'd1, 5'd1, 3'd1),      K_NONE, 32'h0, 32'h0},
    '{32'd120, eb(13'h064, 5'd2, 5'd1, 3'd0),      K_NONE, 32'h0, 32'h0},
    '{32'd124, eb(13'h008, 5'd2, 5'd1, 3'd1),      K_NONE, 32'h0, 32'h0},
    '{32'd132, ej(21'h00010, 5'd5),                K_NONE, 32'h0, 32'h0},
    '{32'd148, es(12'h000, 5'd5, 5'd0),            K_ST, 32'h0, 32'h5},
    '{32'd152, eb(13'h1FD8, 5'd0, 5'd0, 3'd0),     K_NONE, 32'h0, 32'h0},
    '{32'd112, es(12'h000, 5'd1, 5'd0),            K_ST, 32'h0, 32'h5}
  };

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1;
    instr_i = 32'h0000_0013;
    dmem_rdata_i = RDPAT;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc after reset", pc_o, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      instr_i = VEC[i].ins;
      #1;
      chk("R2 R9 R10 pc", pc_o, VEC[i].pc);
      case (VEC[i].kind)
        K_ST: begin
          chk("R7 store strobe", {28'h0, dmem_wstrb_o}, 32'hF);
          chk("R7 store address R3 R4 R5 R6 R11", dmem_addr_o, VEC[i].addr);
          chk("R7 store data R3 R4 R5 R6 R8 R10 R11", dmem_wdata_o, VEC[i].data);
          chk("R8 no load flag on store", {31'h0, dmem_rd_o}, 32'h0);
        end
        K_LD: begin
          chk("R8 load flag", {31'h0, dmem_rd_o}, 32'h1);
          chk("R8 load address", dmem_addr_o, VEC[i].addr);
          chk("R7 no strobe on load", {28'h0, dmem_wstrb_o}, 32'h0);
        end
        default: begin
          chk("R7 no strobe", {28'h0, dmem_wstrb_o}, 32'h0);
          chk("R8 no load flag", {31'h0, dmem_rd_o}, 32'h0);
        end
      endcase
      @(posedge clk);
      @(negedge clk);
    end

    instr_i = ei(12'h000, 5'd0, 3'd0, 5'd0, OI);
    #1;
    chk("R2 pc after final store", pc_o, 32'd116);
    @(posedge clk);
    @(negedge clk);
    chk("R2 sequential step", pc_o, 32'd120);

    instr_i = ej(21'h1FFFF8, 5'd0);
    #1;
    chk("R10 backward jump pending pc", pc_o, 32'd120);
    @(posedge clk);
    @(negedge clk);
    chk("R10 backward jump target", pc_o, 32'd112);

    instr_i = es(12'h000, 5'd5, 5'd0);
    #1;
    chk("R10 rd of jal x0 unchanged x5", dmem_wdata_o, 32'h5);

    rst = 1'b1;
    instr_i = ej(21'h00100, 5'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid-run reset beats jump", pc_o, 32'h0);
    rst = 1'b0;
    instr_i = ei(12'h000, 5'd0, 3'd0, 5'd0, OI);
    @(posedge clk);
    @(negedge clk);
    chk("R1 R2 run resumes from zero", pc_o, 32'd4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule